// File: doc/BRIEF.md
# Scaled Millisecond Delay Unit

This block turns a one-byte delay request into a busy interval measured in whole milliseconds. A caller presents the byte on `operand` together with a one-cycle `start` pulse. The top bit of the byte picks the time scale: either plain milliseconds or hundreds of milliseconds. The lower seven bits hold a count. The count is biased by one, so a count of zero still gives a non-zero delay.

A prescaler divides the system clock down to a one-millisecond tick. Its terminal count is a parameter, `CLK_PER_MS`. The block raises `busy` for the whole interval. When the interval is over, it drops `busy` and pulses `done` for one cycle at the same edge.

A caller uses `busy` as a stall condition, or waits for `done`. Requests that arrive while the block is busy are dropped. For simulation, the block also prints the number of milliseconds that each request lasted.

Top module: `ms_delay_unit`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), busy and done are both 0.
- R2: With operand bit 7 = 0 and bits [6:0] = v, busy stays high for exactly (v+1)·CLK_PER_MS clock cycles. The first millisecond counts a full CLK_PER_MS cycles from the accepting edge.
- R3: With operand bit 7 = 1 and bits [6:0] = v, busy stays high for exactly 100·(v+1)·CLK_PER_MS clock cycles.
- R4: A start pulse seen at a clock edge while busy is low is accepted at that edge, and busy is high in the following cycle.
- R5: done is high for exactly one cycle. It rises at the same edge at which busy falls, and it is never high while busy is high.
- R6: While busy is high, start pulses and changes on operand have no effect on the length of the interval that is running.
- R7: The shortest request (operand 0x00) lasts 1 ms, and the longest (operand 0xFF) lasts 12 800 ms.
- R8: With start held low, busy stays low. A start presented in the cycle where done is high is accepted, so busy rises again after a single idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse; sampled only while idle |
| operand | input | 8 | Bit 7 selects the scale (0: 1 ms, 1: 100 ms); bits [6:0] hold the count minus one |
| busy | output | 1 | High for the whole delay interval |
| done | output | 1 | One-cycle pulse at the end of the interval |

## Verification
The bench measures the length of the busy interval in clock cycles and compares it with a value computed from the operand.

- Random 1x requests over the full count range check that the count is decoded and biased correctly.
- Random 100x requests with small counts show that the scale bit multiplies the delay, rather than being read as part of the count.
- The directed extremes 0x00 and 0xFF exercise both ends of the down-counter's range.
- Requests disturbed by mid-interval start pulses and operand changes show that the operand is captured only at acceptance.
- A request chained in the done cycle shows that the block becomes free again at the expected cycle.

// File: rtl/ms_delay_pkg.sv
// Shared constants and the scaling function of the millisecond delay unit.
// Assumes an 8-bit operand: one scale bit above a 7-bit count.
package ms_delay_pkg;
    localparam int CNT_W = 7;                  // width of the count field
    localparam int OP_W  = CNT_W + 1;          // operand width
    localparam int MS_W  = 14;                 // enough for 100 * 128 = 12800
    localparam logic [7:0] SCALE_HI = 8'd100;  // multiplier of the coarse scale

    // Turns scale bit and count into a total in ms, using only shifts and adds.
    function automatic logic [MS_W-1:0] scale_ms(input logic coarse,
                                                 input logic [CNT_W-1:0] cnt);
        logic [MS_W-1:0] base;
        logic [MS_W-1:0] acc;
        base = MS_W'(cnt) + MS_W'(1);
        acc  = '0;
        for (int b = 0; b < 8; b++) begin
            if (SCALE_HI[b]) acc = acc + (base << b);
        end
        return coarse ? acc : base;
    endfunction
endpackage

// File: rtl/ms_prescaler.sv
// Divides the system clock to a one-millisecond tick.
// Assumes CLK_PER_MS >= 1. The count is held at zero while not running or while
// cleared, so the first tick comes CLK_PER_MS cycles after a restart.
module ms_prescaler #(
    parameter int CLK_PER_MS = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic tick
);
    localparam int PS_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
    localparam logic [PS_W-1:0] LAST = PS_W'(CLK_PER_MS - 1);

    generate
        if (CLK_PER_MS == 1) begin : g_direct
            // Every running cycle is a millisecond.
            assign tick = run && !clear;
        end else begin : g_count
            logic [PS_W-1:0] ps_cnt;

            assign tick = run && !clear && (ps_cnt == LAST);

            // Counts cycles within the current millisecond.
            always_ff @(posedge clk) begin
                if (!rst_n || clear || !run || tick) ps_cnt <= '0;
                else                                 ps_cnt <= ps_cnt + PS_W'(1);
            end
        end
    endgenerate
endmodule

// File: rtl/ms_down_counter.sv
// Holds the remaining milliseconds of a request and flags the last one.
// Assumes that load and dec are never high together, and that it is loaded with a value of at least 1.
module ms_down_counter
    import ms_delay_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [MS_W-1:0] load_val,
    input  logic            dec,
    output logic            last_ms
);
    logic [MS_W-1:0] ms_left;

    assign last_ms = (ms_left == MS_W'(1));

    // Loads the scaled total, then counts it down one step per tick.
    always_ff @(posedge clk) begin
        if (!rst_n)   ms_left <= '0;
        else if (load) ms_left <= load_val;
        else if (dec && !last_ms) ms_left <= ms_left - MS_W'(1);
    end
endmodule

// File: rtl/ms_delay_ctrl.sv
// Sequencing of a delay request: accepts a start while idle, holds busy, and
// emits done at the edge where the last millisecond elapses.
// Assumes that tick arrives only while busy.
module ms_delay_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    input  logic last_ms,
    output logic accept,
    output logic busy,
    output logic done
);
    logic finish;

    assign accept = start && !busy;
    assign finish = busy && tick && last_ms;

    // Busy flag: set on acceptance, cleared when the final tick is consumed.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy <= 1'b0;
        else if (accept) busy <= 1'b1;
        else if (finish) busy <= 1'b0;
    end

    // One-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= finish;
    end
endmodule

// File: rtl/ms_delay_unit.sv
// Top of the scaled millisecond delay unit.
// Assumes a clock of CLK_PER_MS cycles per millisecond. For simulation, it prints
// the number of milliseconds that each request took.
module ms_delay_unit
    import ms_delay_pkg::*;
#(
    parameter int CLK_PER_MS = 100000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [OP_W-1:0] operand,
    output logic            busy,
    output logic            done
);
    logic            accept;
    logic            tick;
    logic            last_ms;
    logic [MS_W-1:0] total_ms;
    logic [MS_W-1:0] elapsed_ms;

    assign total_ms = scale_ms(operand[OP_W-1], operand[CNT_W-1:0]);

    ms_prescaler #(.CLK_PER_MS(CLK_PER_MS)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .run   (busy),
        .tick  (tick)
    );

    ms_down_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (total_ms),
        .dec      (tick),
        .last_ms  (last_ms)
    );

    ms_delay_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .tick    (tick),
        .last_ms (last_ms),
        .accept  (accept),
        .busy    (busy),
        .done    (done)
    );

    // Elapsed-millisecond tally, printed for simulation when a request ends.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) elapsed_ms <= '0;
        else if (tick) begin
            elapsed_ms <= elapsed_ms + MS_W'(1);
            if (last_ms) $display("ms_delay_unit: request lasted %0d ms", elapsed_ms + MS_W'(1));
        end
    end
endmodule

// File: rtl/ms_delay_unit_chk.sv
// Port-level checker of the millisecond delay unit, bound to every instance.
module ms_delay_unit_chk #(
    parameter int CLK_PER_MS = 100000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [7:0] operand,
    input logic       busy,
    input logic       done
);
    localparam longint MAX_CYC = 64'd12800 * CLK_PER_MS;
    longint busy_run;

    // Length of the current busy run.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_run <= 0;
        else                 busy_run <= busy_run + 1;
    end

    p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> (!busy && !done));

    p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_done_at_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_ends_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    p_idle_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);

    p_max_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= MAX_CYC);
endmodule

bind ms_delay_unit ms_delay_unit_chk #(.CLK_PER_MS(CLK_PER_MS)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .operand (operand),
    .busy    (busy),
    .done    (done)
);

// File: tb/ms_delay_unit_tb_top.sv
module ms_delay_unit_tb_top;
    localparam int K = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] operand = 8'h00;
    logic       busy;
    logic       done;
    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    ms_delay_unit #(.CLK_PER_MS(K)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
        .busy(busy), .done(done)
    );

    function automatic longint exp_cycles(input logic [7:0] op);
        longint ms;
        ms = longint'(op[6:0]) + 1;
        if (op[7]) ms = ms * 100;
        return ms * K;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Presents a request at a negedge. Returns at the next negedge, after checking acceptance.
    task automatic issue(input logic [7:0] op);
        start = 1'b1;
        operand = op;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R4 busy after start", longint'(busy), 1);
        check(done == 1'b0, "R5 done low during busy", longint'(done), 0);
    endtask

    // Counts busy cycles. Ends at the negedge where done is high.
    task automatic measure(input logic [7:0] op, input string req, input bit disturb);
        longint cyc;
        longint e;
        cyc = 1;
        e = exp_cycles(op);
        forever begin
            @(negedge clk);
            if (disturb && cyc == 2) begin
                start = 1'b1;
                operand = ~op;
            end else begin
                start = 1'b0;
            end
            if (!busy) break;
            if (done) check(1'b0, "R5 done while busy", 1, 0);
            cyc++;
            if (cyc > e + 8) break;
        end
        check(cyc == e, req, cyc, e);
        check(done == 1'b1, "R5 done at busy fall", longint'(done), 1);
    endtask

    task automatic after_done();
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R5 done single cycle", longint'({busy, done}), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] op;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R1 reset state", longint'({busy, done}), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(busy == 1'b0, "R8 idle without start", longint'(busy), 0);

        // R7: shortest and longest requests.
        issue(8'h00); measure(8'h00, "R7 shortest", 1'b0); after_done();
        issue(8'hFF); measure(8'hFF, "R7 longest", 1'b0); after_done();

        // R2 and R3: random requests.
        for (int i = 0; i < 24; i++) begin
            op = 8'($urandom_range(0, 127));
            if (i % 3 == 2) op = {1'b1, 7'($urandom_range(0, 3))};
            issue(op);
            measure(op, op[7] ? "R3 coarse length" : "R2 fine length", 1'b0);
            after_done();
        end

        // R6: a start pulse and operand changes during busy are ignored.
        issue(8'h05); measure(8'h05, "R6 disturbed fine", 1'b1); after_done();
        issue(8'h81); measure(8'h81, "R6 disturbed coarse", 1'b1); after_done();

        // R8: a start in the done cycle is accepted immediately.
        issue(8'h02); measure(8'h02, "R2 before chain", 1'b0);
        issue(8'h03); measure(8'h03, "R8 chained request", 1'b0); after_done();

        // R1: reset in the middle of a request.
        issue(8'h10);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R1 reset mid-request", longint'({busy, done}), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check(busy == 1'b0, "R8 idle after reset", longint'(busy), 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule